// File: doc/BRIEF.md
# Speculation Fence Sequencing Controller

This controller sits next to the issue stage of an out-of-order core. It turns two kinds of fence request into pipeline control signals. The light request is a throttle. For a fixed run of issued instructions it raises three restriction flags, which hold the core to single, in-order, non-speculative issue. The heavy request is a full fence. It runs a short sequence. First it sends one cycle of cancel pulses, which clear speculation, resource reservations, unmapped rename registers and function units that wait on an operand. It then stalls issue until the function units report no outstanding work. Last it gives a one-cycle completion pulse, and issue resumes.

The full fence starts from a decoded hint or, with no instruction, from an exception, an environment call or an interrupt. All of the signals here are level or pulse controls. There is no data stream, so there is no valid/ready handshake. Every output comes straight from registered state. The issue stall begins in the cycle after the edge that samples the request.

Top module: `spec_fence_ctrl`

## Requirements
- R1: After reset, every output is low and the throttle count is zero.
- R2: A throttle hint raises all three restriction flags after the next clock edge. The flags stay high until 16 issue strobes have been counted after that edge. They fall after the edge that samples the 16th strobe.
- R3: A throttle hint that arrives while a throttle is already active reloads the count to 16. The hint wins over an issue strobe in the same cycle.
- R4: Cycles without an issue strobe do not shorten the throttle.
- R5: A full-fence hint, an exception, an environment call or an interrupt each start a fence sequence. All four cancel outputs are high together, for exactly one cycle, in the cycle after the request is sampled.
- R6: The issue stall is high during the cancel cycle and all drain cycles. It is low in the completion cycle.
- R7: The drain ends at the first edge that samples an outstanding count of zero. The completion pulse follows for one cycle. With zero outstanding work, the completion pulse comes in the third cycle after the request.
- R8: A full fence clears the throttle count. The restriction flags are low from the first drain cycle on.
- R9: Requests that arrive during the cancel or drain cycles are absorbed. They cause no second cancel pulse.
- R10: A request that arrives during the completion cycle starts a new sequence. Its cancel pulse comes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| throttle_hint_i | input | 1 | Decoded throttle hint |
| fence_hint_i | input | 1 | Decoded full-fence hint |
| issue_fire_i | input | 1 | One instruction issued this cycle |
| trap_i | input | 1 | Exception taken |
| ecall_i | input | 1 | Environment call taken |
| irq_i | input | 1 | Interrupt taken |
| outstanding_i | input | CNT_W | Number of instructions not yet committed |
| restrict_spec_o | output | 1 | Suppress speculation |
| restrict_multi_o | output | 1 | Suppress multi-issue |
| restrict_ooo_o | output | 1 | Suppress out-of-order allocation |
| cancel_spec_o | output | 1 | Pulse: cancel speculation |
| cancel_resv_o | output | 1 | Pulse: cancel reservations |
| cancel_rename_o | output | 1 | Pulse: cancel unmapped rename registers |
| cancel_rdwait_o | output | 1 | Pulse: cancel operand-waiting units |
| issue_stall_o | output | 1 | Hold issue |
| fence_done_o | output | 1 | Pulse: fence complete |

## Verification
The bench counts the throttle window exactly, with idle cycles mixed in and a reload partway through. A counter that decrements every cycle, or that ignores the reload, lets restriction drop too early. Requests are sent during the cancel cycle and the drain cycles, where a controller that restarts would give a second cancel pulse. Another request is sent in the completion cycle, where one that drops it would never cancel again. A fence with zero outstanding work checks the minimum cancel–drain–done timing. A fence that starts while a throttle is active shows whether restriction lingers past the drain.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_CANCEL = 2'd1,
    FS_DRAIN  = 2'd2,
    FS_DONE   = 2'd3
  } fence_st_e;

  typedef struct packed {
    logic spec;
    logic resv;
    logic rename;
    logic rdwait;
  } cancel_t;

  localparam int unsigned TRIG_SRCS = 4;

endpackage

// File: rtl/spf_trigger.sv
module spf_trigger #(
  parameter int unsigned N_SRC = spf_pkg::TRIG_SRCS
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);
  logic [N_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_i[g];
  end
  assign any_o = chain[N_SRC];
endmodule

// File: rtl/spf_throttle.sv
module spf_throttle #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  input  logic issue_i,
  output logic active_o
);
  localparam int unsigned TW = $clog2(LEN + 1);
  localparam logic [TW-1:0] RELOAD = TW'(LEN);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (issue_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/spf_fence_fsm.sv
module spf_fence_fsm
  import spf_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] outstanding_i,
  output cancel_t          cancel_o,
  output logic             stall_o,
  output logic             done_o,
  output logic             clear_throttle_o
);
  fence_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE:   if (trig_i) st_d = FS_CANCEL;
      FS_CANCEL: st_d = FS_DRAIN;
      FS_DRAIN:  if (outstanding_i == '0) st_d = FS_DONE;
      FS_DONE:   st_d = trig_i ? FS_CANCEL : FS_IDLE;
      default:   st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  logic in_cancel;
  assign in_cancel        = (st_q == FS_CANCEL);
  assign cancel_o         = '{spec: in_cancel, resv: in_cancel,
                              rename: in_cancel, rdwait: in_cancel};
  assign stall_o          = in_cancel || (st_q == FS_DRAIN);
  assign done_o           = (st_q == FS_DONE);
  assign clear_throttle_o = in_cancel;
endmodule

// File: rtl/spec_fence_ctrl.sv
module spec_fence_ctrl
  import spf_pkg::*;
#(
  parameter int unsigned THROTTLE_LEN = 16,
  parameter int unsigned CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             throttle_hint_i,
  input  logic             fence_hint_i,
  input  logic             issue_fire_i,
  input  logic             trap_i,
  input  logic             ecall_i,
  input  logic             irq_i,
  input  logic [CNT_W-1:0] outstanding_i,
  output logic             restrict_spec_o,
  output logic             restrict_multi_o,
  output logic             restrict_ooo_o,
  output logic             cancel_spec_o,
  output logic             cancel_resv_o,
  output logic             cancel_rename_o,
  output logic             cancel_rdwait_o,
  output logic             issue_stall_o,
  output logic             fence_done_o
);
  logic    fence_req;
  logic    thr_active;
  logic    thr_clear;
  cancel_t cancels;

  spf_trigger #(.N_SRC(TRIG_SRCS)) u_trig (
    .src_i ({fence_hint_i, trap_i, ecall_i, irq_i}),
    .any_o (fence_req)
  );

  spf_fence_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .trig_i           (fence_req),
    .outstanding_i    (outstanding_i),
    .cancel_o         (cancels),
    .stall_o          (issue_stall_o),
    .done_o           (fence_done_o),
    .clear_throttle_o (thr_clear)
  );

  spf_throttle #(.LEN(THROTTLE_LEN)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (throttle_hint_i),
    .clear_i  (thr_clear),
    .issue_i  (issue_fire_i),
    .active_o (thr_active)
  );

  assign restrict_spec_o  = thr_active;
  assign restrict_multi_o = thr_active;
  assign restrict_ooo_o   = thr_active;
  assign cancel_spec_o    = cancels.spec;
  assign cancel_resv_o    = cancels.resv;
  assign cancel_rename_o  = cancels.rename;
  assign cancel_rdwait_o  = cancels.rdwait;
endmodule

// File: rtl/spf_fence_chk.sv
module spf_fence_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             throttle_hint_i,
  input logic             fence_hint_i,
  input logic             trap_i,
  input logic             ecall_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] outstanding_i,
  input logic             restrict_spec_o,
  input logic             cancel_spec_o,
  input logic             cancel_rdwait_o,
  input logic             issue_stall_o,
  input logic             fence_done_o
);
  logic req;
  assign req = fence_hint_i | trap_i | ecall_i | irq_i;

  AST_RESTRICT_ON_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    throttle_hint_i && !cancel_spec_o |=> restrict_spec_o); // R2
  AST_CANCEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_spec_o |=> !cancel_rdwait_o); // R5
  AST_CANCEL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_spec_o |-> $past(req)); // R5
  AST_CANCEL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_spec_o |-> issue_stall_o && !fence_done_o); // R6
  AST_DRAIN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_spec_o |=> issue_stall_o && !fence_done_o); // R7
  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |-> $past(issue_stall_o) && !$past(cancel_spec_o)
                     && $past(outstanding_i) == '0); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |-> !issue_stall_o); // R6
  AST_THROTTLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_spec_o |=> !restrict_spec_o); // R8
endmodule

bind spec_fence_ctrl spf_fence_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .throttle_hint_i (throttle_hint_i),
  .fence_hint_i    (fence_hint_i),
  .trap_i          (trap_i),
  .ecall_i         (ecall_i),
  .irq_i           (irq_i),
  .outstanding_i   (outstanding_i),
  .restrict_spec_o (restrict_spec_o),
  .cancel_spec_o   (cancel_spec_o),
  .cancel_rdwait_o (cancel_rdwait_o),
  .issue_stall_o   (issue_stall_o),
  .fence_done_o    (fence_done_o)
);

// File: tb/test_spec_fence_ctrl.sv
`timescale 1ns/100ps
module test_spec_fence_ctrl;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic th = 1'b0, fh = 1'b0, iss = 1'b0, tr = 1'b0, ec = 1'b0, iq = 1'b0;
  logic [CNT_W-1:0] outs = '0;
  logic r_s, r_m, r_o, c_s, c_r, c_n, c_w, stall, done;

  always #2.5 clk = ~clk;

  spec_fence_ctrl #(.THROTTLE_LEN(16), .CNT_W(CNT_W)) i_spec_fence_ctrl (
    .clk(clk), .rst_n(rst_n),
    .throttle_hint_i(th), .fence_hint_i(fh), .issue_fire_i(iss),
    .trap_i(tr), .ecall_i(ec), .irq_i(iq), .outstanding_i(outs),
    .restrict_spec_o(r_s), .restrict_multi_o(r_m), .restrict_ooo_o(r_o),
    .cancel_spec_o(c_s), .cancel_resv_o(c_r), .cancel_rename_o(c_n),
    .cancel_rdwait_o(c_w), .issue_stall_o(stall), .fence_done_o(done)
  );

  typedef struct {
    logic r, c, s, d;
    string req;
  } exp_t;
  exp_t sb[$];

  int total = 0;
  int bad = 0;
  bit over = 1'b0;

  function automatic void compare(exp_t e);
    logic [3:0] act, ex;
    act = {r_s, c_s, stall, done};
    ex  = {e.r, e.c, e.s, e.d};
    total++;
    if (act !== ex || {r_m, r_o} !== {r_s, r_s} || {c_r, c_n, c_w} !== {3{c_s}}) begin
      bad++;
      $display("FAIL %s: act r%b%b%b c%b%b%b%b s%b d%b exp r=%b c=%b s=%b d=%b",
               e.req, r_s, r_m, r_o, c_s, c_r, c_n, c_w, stall, done,
               e.r, e.c, e.s, e.d);
    end
  endfunction

  // monitor: pops the item pushed one cycle earlier
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) compare(sb.pop_front());
  end

  // driver: apply inputs for one cycle, push outputs expected after the edge
  task automatic cyc(input logic t_th, input logic t_fh, input logic t_iss,
                     input logic t_tr, input logic t_ec, input logic t_iq,
                     input int t_outs, input logic er, input logic ecn,
                     input logic es, input logic ed, input string req);
    exp_t e;
    @(negedge clk);
    #1;
    th = t_th; fh = t_fh; iss = t_iss; tr = t_tr; ec = t_ec; iq = t_iq;
    outs = CNT_W'(t_outs);
    e.r = er; e.c = ecn; e.s = es; e.d = ed; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input logic er, input string req);
    cyc(0,0,0,0,0,0,0, er,0,0,0, req);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!over) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    begin
      exp_t e; e.r = 0; e.c = 0; e.s = 0; e.d = 0; e.req = "R1";
      compare(e);
    end

    // R2 / R4: throttle window of 16 issues with idle gaps
    cyc(1,0,0,0,0,0,0, 1,0,0,0, "R2");
    for (int i = 1; i <= 15; i++) begin
      cyc(0,0,1,0,0,0,0, 1,0,0,0, "R2");
      if (i == 5 || i == 15) begin
        idle(1, "R4"); idle(1, "R4");
      end
    end
    cyc(0,0,1,0,0,0,0, 0,0,0,0, "R2");
    cyc(0,0,1,0,0,0,0, 0,0,0,0, "R2");

    // R3: reload mid-window, hint and issue together
    cyc(1,0,0,0,0,0,0, 1,0,0,0, "R3");
    for (int i = 0; i < 10; i++) cyc(0,0,1,0,0,0,0, 1,0,0,0, "R3");
    cyc(1,0,1,0,0,0,0, 1,0,0,0, "R3");
    for (int i = 0; i < 15; i++) cyc(0,0,1,0,0,0,0, 1,0,0,0, "R3");
    cyc(0,0,1,0,0,0,0, 0,0,0,0, "R3");

    // R8 / R7: fence hint with throttle active, no outstanding work
    cyc(1,0,0,0,0,0,0, 1,0,0,0, "R8");
    cyc(0,1,0,0,0,0,0, 1,1,1,0, "R5");
    cyc(0,0,0,0,0,0,0, 0,0,1,0, "R8");
    cyc(0,0,0,0,0,0,0, 0,0,0,1, "R7");
    idle(0, "R7");

    // R9 / R6: exception with outstanding work, requests absorbed
    cyc(0,0,0,1,0,0,3, 0,1,1,0, "R5");
    cyc(0,0,0,0,0,1,3, 0,0,1,0, "R9");
    cyc(0,0,0,0,1,0,2, 0,0,1,0, "R9");
    cyc(0,1,0,0,0,0,1, 0,0,1,0, "R6");
    cyc(0,0,0,0,0,0,0, 0,0,0,1, "R6");

    // R10: request during completion cycle restarts
    cyc(0,0,0,0,1,0,0, 0,1,1,0, "R10");
    cyc(0,0,0,0,0,0,0, 0,0,1,0, "R10");
    cyc(0,0,0,0,0,0,0, 0,0,0,1, "R10");
    idle(0, "R10");

    // R5: interrupt and environment call from idle
    cyc(0,0,0,0,0,1,1, 0,1,1,0, "R5");
    cyc(0,0,0,0,0,0,0, 0,0,1,0, "R5");
    cyc(0,0,0,0,0,0,0, 0,0,0,1, "R5");
    idle(0, "R5");
    cyc(0,0,0,0,1,0,0, 0,1,1,0, "R5");
    cyc(0,0,0,0,0,0,0, 0,0,1,0, "R5");
    cyc(0,0,0,0,0,0,0, 0,0,0,1, "R5");
    idle(0, "R5");

    @(negedge clk);
    @(negedge clk);
    over = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule